// File: doc/BRIEF.md
# Two-Request Mutual-Exclusion Arbiter with Filtered Grants and Failure Detector

This block is a test harness around a two-input mutual-exclusion arbiter. A launch input, which is asynchronous to the clock, passes through a synchronizer. Its rising edge produces a one-clock capture pulse. On that pulse the two active-high request inputs are stored in flip-flops. The stored requests drive a cross-coupled pair of NAND gates that acts as the arbitration latch. The gate model has equal delay on both sides, so each NAND output is re-evaluated once per clock from the state of the previous clock. When both requests reach an idle latch at the same moment, the symmetric pair never settles and toggles between both-low and both-high. This is the cycle-level picture of a latch that cannot decide.

Each latch output reaches its grant only through a 4-input NOR filter. The filter looks at both latch outputs, now and one clock earlier, and raises a grant only when the two outputs have been cleanly apart for two consecutive samples. A detector watches the two filtered grants. If both are ever high together, it sets a sticky failure flag. That flag holds until the next launch capture, so a tester can read it at any time after the arbitration. A parameter can remove the filter and send the raw latch outputs to the grants instead. This exposes the failure path, which lets the detector be shown to work.

Top module: `arb_mutex_harness`

## Requirements
- R1: After synchronous reset (rst high at a rising edge), grant_a_o, grant_b_o and fail_o are all 0, and the latch is idle (both NAND outputs high).
- R2: launch_i passes through SYNC_STAGES flip-flops. Requests are captured only on the clock where the synchronized launch goes from 0 to 1. Request changes while launch stays low, or while launch is held high, have no effect on the grants.
- R3: With only req_a_i captured from an idle latch, grant_a_o rises and grant_b_o stays 0. grant_a_o is first seen high after the (SYNC_STAGES+3)th rising edge, counted from the first edge that samples launch_i high.
- R4: With only req_b_i captured, grant_b_o rises and grant_a_o stays 0. Moving from a held A grant to a sole B request passes through one idle latch clock before B is granted.
- R5: When both requests are captured while one side already holds the grant, that side keeps the grant and the other stays 0.
- R6: When both requests are captured with the latch idle, the equal-delay latch toggles between both-low and both-high outputs every clock. With FILTER_EN=1 neither grant is raised and fail_o stays 0.
- R7: With FILTER_EN=1, grant_a_o and grant_b_o are never 1 on the same clock.
- R8: If both grants are 1 on a clock, fail_o is 1 from the next clock on and stays 1 until the next capture. With FILTER_EN=0, a simultaneous request pair from idle therefore sets fail_o.
- R9: The capture clock of a new launch clears fail_o, and the clear takes priority over a set on that same clock. A launch with no requests, made from an idle latch, leaves fail_o at 0.
- R10: With FILTER_EN=1, a grant is raised only when its own latch output is low and the opposite output is high, in both the current clock and the previous clock (4-input NOR of the inverted conditions). With FILTER_EN=0, a grant is the inverse of its own latch output.
- R11: When no request is captured, the latch returns to idle one clock after the capture and both grants fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every register |
| rst | input | 1 | Synchronous active-high reset |
| launch_i | input | 1 | Asynchronous launch; a rising edge captures the requests |
| req_a_i | input | 1 | Request A, active high |
| req_b_i | input | 1 | Request B, active high |
| grant_a_o | output | 1 | Filtered grant for A |
| grant_b_o | output | 1 | Filtered grant for B |
| fail_o | output | 1 | Sticky flag: both grants were seen high since the last capture |

## Verification
The hardest state to reach from the ports is two requests arriving at an idle latch on the very same clock, because that is the only route into the oscillating undecided state. The stimulus first launches with no request so the latch is idle. It then sets both request pins before a single launch edge. A second instance with the filter removed receives the same pins, so one run shows both the suppressed grants and the failure flag being set. The flag is then cleared by two further empty launches, which leave the latch idle.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // One bit per requester side.
    typedef struct packed {
        logic a;
        logic b;
    } pair_t;

    // Both NAND outputs high: no side holds the latch.
    localparam pair_t LATCH_IDLE = '{a: 1'b1, b: 1'b1};
    localparam pair_t PAIR_ZERO  = '{a: 1'b0, b: 1'b0};

    // One evaluation of the cross-coupled NAND pair, equal delay on both sides.
    function automatic pair_t nand_step(input pair_t req, input pair_t x);
        pair_t n;
        n.a = ~(req.a & x.b);
        n.b = ~(req.b & x.a);
        return n;
    endfunction

    function automatic logic nor4(input logic [3:0] v);
        return ~|v;
    endfunction

endpackage

// File: rtl/arb_launch_sync.sv
module arb_launch_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic launch_i,
    output logic cap_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= launch_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[LAST];
    end

    assign cap_o = sync_q[LAST] & ~prev_q;

    // R2: a capture pulse is one clock wide
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cap_o |=> !cap_o);

endmodule

// File: rtl/arb_req_capture.sv
module arb_req_capture
    import arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap_i,
    input  pair_t req_i,
    output pair_t req_q
);
    always_ff @(posedge clk) begin
        if (rst)        req_q <= PAIR_ZERO;
        else if (cap_i) req_q <= req_i;
    end

    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        cap_i |=> (req_q == $past(req_i)));

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(req_q));

endmodule

// File: rtl/arb_nand_core.sv
module arb_nand_core
    import arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pair_t req_i,
    output pair_t x_q,
    output pair_t x_d
);
    pair_t x_next;

    always_comb x_next = nand_step(req_i, x_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q <= LATCH_IDLE;
            x_d <= LATCH_IDLE;
        end else begin
            x_q <= x_next;
            x_d <= x_q;
        end
    end

    // R11: with no request held, the pair returns to idle
    p_idle_release_r11: assert property (@(posedge clk) disable iff (rst)
        (req_i == PAIR_ZERO) |=> (x_q == LATCH_IDLE));

    // R5: a side that is held low while its request stays keeps it
    p_holder_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        (req_i.a && !x_q.a && x_q.b) |=> (!x_q.a && x_q.b));

endmodule

// File: rtl/arb_meta_filter.sv
module arb_meta_filter
    import arb_pkg::*;
#(
    parameter bit FILTER_EN = 1'b1
) (
    input  pair_t x_i,
    input  pair_t xd_i,
    output pair_t grant_o
);
    generate
        if (FILTER_EN) begin : g_filter
            always_comb begin
                grant_o.a = nor4({x_i.a, ~x_i.b, xd_i.a, ~xd_i.b});
                grant_o.b = nor4({x_i.b, ~x_i.a, xd_i.b, ~xd_i.a});
            end
        end else begin : g_raw
            logic unused_d;
            assign unused_d = ^xd_i;
            always_comb begin
                grant_o.a = ~x_i.a;
                grant_o.b = ~x_i.b;
            end
        end
    endgenerate

endmodule

// File: rtl/arb_fail_latch.sv
module arb_fail_latch
    import arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr_i,
    input  pair_t grant_i,
    output logic  fail_o
);
    logic both_hi;

    always_comb both_hi = grant_i.a & grant_i.b;

    always_ff @(posedge clk) begin
        if (rst)          fail_o <= 1'b0;
        else if (clr_i)   fail_o <= 1'b0;
        else if (both_hi) fail_o <= 1'b1;
    end

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !fail_o);

    p_set_r8: assert property (@(posedge clk) disable iff (rst)
        (grant_i.a && grant_i.b && !clr_i) |=> fail_o);

    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (fail_o && !clr_i) |=> fail_o);

endmodule

// File: rtl/arb_mutex_harness.sv
module arb_mutex_harness
    import arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit FILTER_EN   = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic launch_i,
    input  logic req_a_i,
    input  logic req_b_i,
    output logic grant_a_o,
    output logic grant_b_o,
    output logic fail_o
);
    logic  cap;
    pair_t req_in;
    pair_t req_q;
    pair_t x_q;
    pair_t x_d;
    pair_t grant;

    always_comb begin
        req_in.a = req_a_i;
        req_in.b = req_b_i;
    end

    arb_launch_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .launch_i (launch_i),
        .cap_o    (cap)
    );

    arb_req_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .cap_i (cap),
        .req_i (req_in),
        .req_q (req_q)
    );

    arb_nand_core u_core (
        .clk   (clk),
        .rst   (rst),
        .req_i (req_q),
        .x_q   (x_q),
        .x_d   (x_d)
    );

    arb_meta_filter #(.FILTER_EN(FILTER_EN)) u_filt (
        .x_i     (x_q),
        .xd_i    (x_d),
        .grant_o (grant)
    );

    arb_fail_latch u_fail (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (cap),
        .grant_i (grant),
        .fail_o  (fail_o)
    );

    assign grant_a_o = grant.a;
    assign grant_b_o = grant.b;

    generate
        if (FILTER_EN) begin : g_excl_chk
            // R7: filtered grants never overlap
            p_grant_excl_r7: assert property (@(posedge clk) disable iff (rst)
                !(grant_a_o && grant_b_o));
            // R10: a grant needs its latch side low on the previous clock too
            p_two_sample_r10: assert property (@(posedge clk) disable iff (rst)
                $rose(grant_a_o) |-> ($past(x_q.b) && !$past(x_q.a)));
        end
    endgenerate

endmodule

// File: tb/arb_mutex_harness_test.sv
`timescale 1ns/1ps
module arb_mutex_harness_test;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic launch = 1'b0;
    logic req_a = 1'b0;
    logic req_b = 1'b0;
    logic ga, gb, fl;
    logic rga, rgb, rfl;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    arb_mutex_harness #(.SYNC_STAGES(S), .FILTER_EN(1'b1)) uut (
        .clk(clk), .rst(rst), .launch_i(launch), .req_a_i(req_a), .req_b_i(req_b),
        .grant_a_o(ga), .grant_b_o(gb), .fail_o(fl));

    arb_mutex_harness #(.SYNC_STAGES(S), .FILTER_EN(1'b0)) uut_raw (
        .clk(clk), .rst(rst), .launch_i(launch), .req_a_i(req_a), .req_b_i(req_b),
        .grant_a_o(rga), .grant_b_o(rgb), .fail_o(rfl));

    // Behavioural reference: gate outputs held as integers, launch history in a queue.
    int hist[$];
    int last_seen, ra, rb, xa, xb, pa, pb, fail_f, fail_r;

    function automatic int inv(int v); return (v == 0) ? 1 : 0; endfunction

    function automatic int fgrant(int own, int oth, int own_p, int oth_p);
        return (own == 0 && oth == 1 && own_p == 0 && oth_p == 1) ? 1 : 0;
    endfunction

    task automatic model_reset();
        hist = {};
        for (int i = 0; i < S; i++) hist.push_back(0);
        last_seen = 0; ra = 0; rb = 0;
        xa = 1; xb = 1; pa = 1; pb = 1;
        fail_f = 0; fail_r = 0;
    endtask

    task automatic model_step();
        int newest, cap, na, nb, fa, fb;
        newest = hist[S-1];
        cap = (newest == 1 && last_seen == 0) ? 1 : 0;
        na = inv(ra & xb);
        nb = inv(rb & xa);
        fa = fgrant(xa, xb, pa, pb);
        fb = fgrant(xb, xa, pb, pa);
        if (cap) fail_f = 0; else if (fa == 1 && fb == 1) fail_f = 1;
        if (cap) fail_r = 0; else if (xa == 0 && xb == 0) fail_r = 1;
        pa = xa; pb = xb; xa = na; xb = nb;
        if (cap) begin ra = int'(req_a); rb = int'(req_b); end
        last_seen = newest;
        void'(hist.pop_back());
        hist.push_front(int'(launch));
    endtask

    task automatic check_bit(string what, logic act, int exp);
        checks++;
        if (act !== exp[0]) begin
            fails++;
            $display("FAIL %s %s: actual=%0b expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check_bit("grant_a",     ga,  fgrant(xa, xb, pa, pb));
        check_bit("grant_b",     gb,  fgrant(xb, xa, pb, pa));
        check_bit("fail",        fl,  fail_f);
        check_bit("raw grant_a", rga, inv(xa));
        check_bit("raw grant_b", rgb, inv(xb));
        check_bit("raw fail",    rfl, fail_r);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic launch_with(logic a, logic b);
        req_a = a; req_b = b; launch = 1'b1;
        run(4);
        launch = 1'b0;
        run(12);
    endtask

    initial begin
        int lat;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        tag = "R1";
        check_bit("reset grant_a", ga, 0);
        check_bit("reset grant_b", gb, 0);
        check_bit("reset fail", fl, 0);
        run(3);

        // R3 and R10: latency of a sole A request from idle
        tag = "R3";
        req_a = 1'b1; req_b = 1'b0; launch = 1'b1;
        lat = 0;
        for (int i = 1; i <= 10; i++) begin
            tick();
            if (ga === 1'b1 && lat == 0) lat = i;
        end
        launch = 1'b0;
        run(6);
        tag = "R10";
        checks++;
        if (lat != S + 3) begin
            fails++;
            $display("FAIL R10 grant latency: actual=%0d expected=%0d", lat, S + 3);
        end
        tag = "R3";
        check_bit("A granted", ga, 1);
        check_bit("B idle", gb, 0);

        // R5: A already holds, both request
        tag = "R5";
        launch_with(1'b1, 1'b1);
        check_bit("holder A keeps", ga, 1);
        check_bit("B refused", gb, 0);

        // R4: handover to sole B
        tag = "R4";
        launch_with(1'b0, 1'b1);
        check_bit("B granted", gb, 1);
        check_bit("A released", ga, 0);

        // R11: empty launch releases everything
        tag = "R11";
        launch_with(1'b0, 1'b0);
        check_bit("no grant a", ga, 0);
        check_bit("no grant b", gb, 0);

        // R2: request changes without a launch edge are ignored
        tag = "R2";
        req_a = 1'b1; req_b = 1'b0;
        run(10);
        check_bit("no capture without launch", ga, 0);
        req_a = 1'b0; launch = 1'b1;
        run(5);
        req_a = 1'b1;
        run(10);
        check_bit("no capture while launch high", ga, 0);
        launch = 1'b0;
        run(6);
        check_bit("still idle", ga, 0);

        // R6, R7, R8: simultaneous requests into an idle latch
        tag = "R6";
        launch_with(1'b1, 1'b1);
        check_bit("filtered grant_a suppressed", ga, 0);
        check_bit("filtered grant_b suppressed", gb, 0);
        check_bit("filtered fail low", fl, 0);
        tag = "R8";
        check_bit("raw fail set", rfl, 1);
        run(20);
        check_bit("raw fail sticky", rfl, 1);
        tag = "R7";
        run(7);

        // R9: clear on the next captures
        tag = "R9";
        launch_with(1'b0, 1'b0);
        launch_with(1'b0, 1'b0);
        check_bit("raw fail cleared", rfl, 0);
        check_bit("filtered fail low", fl, 0);

        // R3 again from idle with B ahead then A
        tag = "R4";
        launch_with(1'b0, 1'b1);
        check_bit("B from idle", gb, 1);
        tag = "R3";
        launch_with(1'b1, 1'b0);
        check_bit("A after B", ga, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule